// File: doc/BRIEF.md
# NAND Hamming Syndrome Classifier and Bit Fixer

This block takes two 24-bit Hamming check words for one 256-byte unit of NAND data. One word is computed from the data just read and the other comes from the spare area. The block XORs them into a syndrome and decides which of four cases applies. The data is clean, a single data bit is wrong and can be repaired, the stored check word itself is damaged, or the damage cannot be repaired. When a repair is possible, the block gives the byte position inside the unit and the bit index inside that byte. Each of these comes from complementary bit pairs in the syndrome.

The caller pulses `start` with both words present. One clock later, `done` pulses and the result is registered. The result holds until the next `start`. The caller then fetches the byte at the reported offset, presents it on `data_in` and receives the repaired byte on `data_out`. The offset counts from the start of the 256-byte unit, so the caller adds the unit's base address. For larger pages the caller runs the block once per unit.

The control is a two-state machine:
- `S_IDLE` waits for `start`. `start` moves it to `S_REPORT`.
- `S_REPORT` is the single cycle in which `done` is high. It moves to `S_REPORT` again on another `start`, otherwise to `S_IDLE`.
- Reset forces `S_IDLE`.

Top module: `nand_ecc_fixer`

## Requirements
- R1: The syndrome is calc_code XOR stored_code restricted to bits 15:0 (line pairs) and bits 23:18 (column pairs). Bits 17:16 of either word never affect any output.
- R2: A syndrome of all zeros yields status 2'b00 (clean).
- R3: A syndrome with exactly one bit set yields status 2'b10 (stored check word damaged).
- R4: If every pair (bits 2k+1:2k for k=0..7, and bits 19:18, 21:20, 23:22) is 01 or 10, the status is 2'b01 (corrected). Otherwise, a nonzero syndrome with more than one bit set gives status 2'b11 (uncorrectable).
- R5: On status 01, byte_ofs bit k equals 1 when line pair k (bits 2k+1:2k) reads 10 and 0 when it reads 01. The pair at bits 15:14 gives the MSB. Line pairs 10 10 01 10 01 01 10 10 give 0xD3.
- R6: On status 01, bit_idx bit j equals 1 when column pair j (bits 18+2j+1:18+2j) reads 10 and 0 when it reads 01. The pair at bits 23:22 gives the MSB. Column pairs 10 01 10 give bit index 5.
- R7: For any status other than 01, byte_ofs and bit_idx are zero.
- R8: done is high in exactly the cycle after a cycle with start high, and low otherwise. status, byte_ofs and bit_idx change only on the clock edge that samples start high.
- R9: data_out equals data_in XOR (1 << bit_idx) when status is 01, and equals data_in otherwise. data_out is combinational from data_in.
- R10: A synchronous active-high reset sets status to 00, byte_ofs and bit_idx to 0, and done to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the two check words this cycle |
| calc_code | input | 24 | Check word computed from the data just read |
| stored_code | input | 24 | Check word read from the spare area |
| data_in | input | 8 | Byte fetched from the reported offset |
| status | output | 2 | 00 clean, 01 corrected, 10 check word damaged, 11 uncorrectable |
| byte_ofs | output | 8 | Byte offset inside the 256-byte unit |
| bit_idx | output | 3 | Bit index of the faulty bit |
| data_out | output | 8 | Repaired byte |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
If the state register is wrong, it shows on `done` in the cycle right after `start`. The symptom is either a missing pulse or a pulse that lasts two cycles. A fault in the classification or the pair decoding shows on `status`, `byte_ofs` or `bit_idx` in that same first cycle. The worked 0xD3/bit-5 case and offsets at both ends of the range expose bit-order mistakes. A wrong correction mask shows on `data_out` as soon as a byte is applied, in the same cycle.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN   = 2'b00,
        ST_FIXED   = 2'b01,
        ST_CODEERR = 2'b10,
        ST_UNCORR  = 2'b11
    } fix_status_e;

    typedef enum logic {
        S_IDLE,
        S_REPORT
    } fix_state_e;
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
    parameter int LINE_PAIRS = 8,
    parameter int COL_PAIRS  = 3,
    localparam int CODE_W    = 2*LINE_PAIRS + 2 + 2*COL_PAIRS,
    localparam int COL_LSB   = 2*LINE_PAIRS + 2,
    localparam int KEPT_W    = 2*(LINE_PAIRS + COL_PAIRS)
) (
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output logic [KEPT_W-1:0] kept,
    output logic              is_zero,
    output logic              is_single,
    output logic              all_valid
);
    localparam int NP = LINE_PAIRS + COL_PAIRS;

    logic [NP-1:0] pair_ok;

    // Reserved bits between the line and column fields are skipped entirely (R1).
    assign kept = {calc_code[CODE_W-1:COL_LSB]     ^ stored_code[CODE_W-1:COL_LSB],
                   calc_code[2*LINE_PAIRS-1:0]     ^ stored_code[2*LINE_PAIRS-1:0]};

    for (genvar p = 0; p < NP; p++) begin : g_pair
        assign pair_ok[p] = kept[2*p] ^ kept[2*p+1];
    end

    assign is_zero   = (kept == '0);
    assign is_single = !is_zero && ((kept & (kept - 1'b1)) == '0);
    assign all_valid = &pair_ok;
endmodule

// File: rtl/ecc_pair_decode.sv
module ecc_pair_decode #(
    parameter int NPAIRS = 8
) (
    input  logic [2*NPAIRS-1:0] pairs,
    output logic [NPAIRS-1:0]   value
);
    // 10 -> 1, 01 -> 0; pair i lands on bit i so the top pair is the MSB.
    for (genvar i = 0; i < NPAIRS; i++) begin : g_bit
        assign value[i] = pairs[2*i+1] & ~pairs[2*i];
    end
endmodule

// File: rtl/ecc_bit_flip.sv
module ecc_bit_flip #(
    parameter int IDX_W = 3,
    localparam int DATA_W = 2**IDX_W
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic              enable,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] mask;

    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign mask[b] = enable && (idx == IDX_W'(b));
    end

    assign data_out = data_in ^ mask;
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
    import ecc_fix_pkg::*;
#(
    parameter int LINE_PAIRS = 8,
    parameter int COL_PAIRS  = 3,
    localparam int CODE_W    = 2*LINE_PAIRS + 2 + 2*COL_PAIRS,
    localparam int BYTE_W    = 2**COL_PAIRS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [CODE_W-1:0]     calc_code,
    input  logic [CODE_W-1:0]     stored_code,
    input  logic [BYTE_W-1:0]     data_in,
    output logic [1:0]            status,
    output logic [LINE_PAIRS-1:0] byte_ofs,
    output logic [COL_PAIRS-1:0]  bit_idx,
    output logic [BYTE_W-1:0]     data_out,
    output logic                  done
);
    localparam int KEPT_W = 2*(LINE_PAIRS + COL_PAIRS);

    fix_state_e  state, state_nxt;
    fix_status_e class_nxt, status_q;

    logic [KEPT_W-1:0]     kept;
    logic                  is_zero, is_single, all_valid;
    logic [LINE_PAIRS-1:0] ofs_dec;
    logic [COL_PAIRS-1:0]  idx_dec;

    ecc_syndrome #(.LINE_PAIRS(LINE_PAIRS), .COL_PAIRS(COL_PAIRS)) u_syn (
        .calc_code  (calc_code),
        .stored_code(stored_code),
        .kept       (kept),
        .is_zero    (is_zero),
        .is_single  (is_single),
        .all_valid  (all_valid)
    );

    ecc_pair_decode #(.NPAIRS(LINE_PAIRS)) u_line_dec (
        .pairs(kept[2*LINE_PAIRS-1:0]),
        .value(ofs_dec)
    );

    ecc_pair_decode #(.NPAIRS(COL_PAIRS)) u_col_dec (
        .pairs(kept[KEPT_W-1:2*LINE_PAIRS]),
        .value(idx_dec)
    );

    ecc_bit_flip #(.IDX_W(COL_PAIRS)) u_flip (
        .data_in (data_in),
        .idx     (bit_idx),
        .enable  (status_q == ST_FIXED),
        .data_out(data_out)
    );

    // Classification priority: zero, single bit, all pairs complementary, else bad.
    always_comb begin
        if (is_zero)        class_nxt = ST_CLEAN;
        else if (is_single) class_nxt = ST_CODEERR;
        else if (all_valid) class_nxt = ST_FIXED;
        else                class_nxt = ST_UNCORR;
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:   state_nxt = start ? S_REPORT : S_IDLE;
            S_REPORT: state_nxt = start ? S_REPORT : S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nxt;
    end

    // Result registers, loaded on the edge that enters S_REPORT from a start.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= ST_CLEAN;
            byte_ofs <= '0;
            bit_idx  <= '0;
        end else if (start) begin
            status_q <= class_nxt;
            byte_ofs <= (class_nxt == ST_FIXED) ? ofs_dec : '0;
            bit_idx  <= (class_nxt == ST_FIXED) ? idx_dec : '0;
        end
    end

    assign status = status_q;
    assign done   = (state == S_REPORT);

    a_r8_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r8_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(status) && $stable(byte_ofs) && $stable(bit_idx)));
    a_r7_fields_zero: assert property (@(posedge clk) disable iff (rst)
        (status != 2'b01) |-> (byte_ofs == '0 && bit_idx == '0));
    a_r9_one_bit_flipped: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b01) |-> ($countones(data_out ^ data_in) == 1));
    a_r9_pass_through: assert property (@(posedge clk) disable iff (rst)
        (status != 2'b01) |-> (data_out == data_in));
    a_r3_single_not_pairs: assert property (@(posedge clk) disable iff (rst)
        is_single |-> !all_valid);
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (status == 2'b00 && byte_ofs == '0 && bit_idx == '0 && !done));
endmodule

// File: tb/test_nand_ecc_fixer.sv
module test_nand_ecc_fixer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] stored_code = '0;
    logic [7:0]  data_in = '0;
    logic [1:0]  status;
    logic [7:0]  byte_ofs;
    logic [2:0]  bit_idx;
    logic [7:0]  data_out;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nand_ecc_fixer i_nand_ecc_fixer (
        .clk(clk), .rst(rst), .start(start),
        .calc_code(calc_code), .stored_code(stored_code),
        .data_in(data_in), .status(status), .byte_ofs(byte_ofs),
        .bit_idx(bit_idx), .data_out(data_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_syn(input logic [7:0] ofs, input logic [2:0] bi);
        logic [23:0] s = '0;
        for (int i = 0; i < 8; i++) s[2*i +: 2] = ofs[i] ? 2'b10 : 2'b01;
        for (int j = 0; j < 3; j++) s[18+2*j +: 2] = bi[j] ? 2'b10 : 2'b01;
        return s;
    endfunction

    // Present both words with start for one cycle; return one cycle later.
    task automatic run(input logic [23:0] c, input logic [23:0] s);
        @(negedge clk);
        calc_code = c; stored_code = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk(status == 2'b00, "R10 status", status, 0);
        chk(byte_ofs == 8'h00 && bit_idx == 3'd0, "R10 fields", {byte_ofs, bit_idx}, 0);
        chk(done == 1'b0, "R10 done", done, 0);
    endtask

    task automatic t_clean;
        run(24'h5A3C71, 24'h5A3C71);
        chk(done == 1'b1, "R8 done pulse", done, 1);
        chk(status == 2'b00, "R2 clean", status, 0);
        data_in = 8'hC4; #1;
        chk(data_out == 8'hC4, "R9 passthrough clean", data_out, 8'hC4);
        @(negedge clk);
        chk(done == 1'b0, "R8 single pulse", done, 0);
    endtask

    task automatic t_example;
        run(24'h123456, 24'h123456 ^ 24'h98A65A);
        chk(status == 2'b01, "R4 example corrected", status, 1);
        chk(byte_ofs == 8'hD3, "R5 example offset", byte_ofs, 8'hD3);
        chk(bit_idx == 3'd5, "R6 example bit", bit_idx, 5);
        data_in = 8'h00; #1;
        chk(data_out == 8'h20, "R9 flip bit5", data_out, 8'h20);
        data_in = 8'hFF; #1;
        chk(data_out == 8'hDF, "R9 flip bit5 ones", data_out, 8'hDF);
    endtask

    task automatic t_sweep;
        logic [7:0] ofs_l [4] = '{8'h00, 8'hFF, 8'h80, 8'h01};
        logic [2:0] bi_l  [4] = '{3'd0, 3'd7, 3'd3, 3'd6};
        for (int k = 0; k < 4; k++) begin
            run(24'hA5F00F, 24'hA5F00F ^ mk_syn(ofs_l[k], bi_l[k]));
            chk(status == 2'b01, "R4 sweep corrected", status, 1);
            chk(byte_ofs == ofs_l[k], "R5 sweep offset", byte_ofs, ofs_l[k]);
            chk(bit_idx == bi_l[k], "R6 sweep bit", bit_idx, bi_l[k]);
            data_in = 8'h5A; #1;
            chk(data_out == (8'h5A ^ (8'h1 << bi_l[k])), "R9 sweep flip",
                data_out, 8'h5A ^ (8'h1 << bi_l[k]));
        end
    endtask

    task automatic t_ignored;
        run(24'h000000, 24'h030000);
        chk(status == 2'b00, "R1 gap bits both", status, 0);
        run(24'h010000, 24'h000000);
        chk(status == 2'b00, "R1 gap bit single", status, 0);
        run(24'h123456, 24'h123456 ^ 24'h98A65A ^ 24'h020000);
        chk(status == 2'b01 && byte_ofs == 8'hD3, "R1 gap with error", {status, byte_ofs}, 10'h1D3);
    endtask

    task automatic t_code_err;
        run(24'h777777, 24'h777777 ^ 24'h100000);
        chk(status == 2'b10, "R3 column bit", status, 2);
        chk(byte_ofs == 8'h00 && bit_idx == 3'd0, "R7 code err fields", {byte_ofs, bit_idx}, 0);
        run(24'h000001, 24'h000000);
        chk(status == 2'b10, "R3 line bit", status, 2);
        data_in = 8'h3C; #1;
        chk(data_out == 8'h3C, "R9 passthrough code err", data_out, 8'h3C);
    endtask

    task automatic t_uncorr;
        // pair at bits 13:12 is 11
        run(24'h000000, 24'h98B65A);
        chk(status == 2'b11, "R4 pair 11", status, 3);
        chk(byte_ofs == 8'h00 && bit_idx == 3'd0, "R7 uncorr fields", {byte_ofs, bit_idx}, 0);
        // column pair at bits 23:22 is 00
        run(24'h000000, 24'h18A65A);
        chk(status == 2'b11, "R4 pair 00", status, 3);
        data_in = 8'h81; #1;
        chk(data_out == 8'h81, "R9 passthrough uncorr", data_out, 8'h81);
    endtask

    task automatic t_hold_and_b2b;
        run(24'h0, 24'h98A65A);
        @(negedge clk);
        calc_code = 24'h0; stored_code = 24'h000001;
        @(negedge clk);
        chk(status == 2'b01 && byte_ofs == 8'hD3 && bit_idx == 3'd5, "R8 hold without start",
            {status, byte_ofs, bit_idx}, {2'b01, 8'hD3, 3'd5});
        chk(done == 1'b0, "R8 no done without start", done, 0);
        @(negedge clk);
        calc_code = 24'h0; stored_code = 24'h98A65A; start = 1'b1;
        @(negedge clk);
        calc_code = 24'h0; stored_code = 24'h0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && status == 2'b00, "R8 back-to-back second", {done, status}, 4);
    endtask

    task automatic t_mid_reset;
        run(24'h0, 24'h98A65A);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(status == 2'b00 && byte_ofs == 8'h00 && bit_idx == 3'd0 && done == 1'b0,
            "R10 mid reset", {status, byte_ofs, bit_idx, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean();
        t_example();
        t_sweep();
        t_ignored();
        t_code_err();
        t_uncorr();
        t_hold_and_b2b();
        t_mid_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule